// File: doc/BRIEF.md
# External Bus Master Bank Decode Front End

This block lets a bus master outside the chip reach slaves through the memory controller's bank decode. Two kinds of master are served. A clock-synchronous master starts a transfer by pulsing a transfer-start input for one clock. An asynchronous master drives the address and raises an address strobe with no relation to the clock; the strobe is brought into the clock domain through a two-flop synchronizer before anything acts on it.

On a start the address is captured and, one clock later, compared against every bank's base and mask. When a valid bank matches, the block drives that bank's chip select and a transfer acknowledge back to the master. A miss drives neither. Each kind of master has its own enable input; with an enable low, starts of that kind are ignored and the block stays quiet, so the master can run the slave on its own. Burst sequencing and slave timing generation are not part of this block.

The start and strobe inputs are plain control pins rather than a valid/ready stream: the master never waits on a ready, and a start that arrives while a transfer is in progress is dropped rather than held back. Back-pressure therefore does not exist at this edge; the acknowledge is the only reply.

Top module: `ext_master_frontend`

## Requirements
- R1: While reset is held and after its release with no start, `bank_cs_o` is all zero and `ack_o` is low.
- R2: With `sync_en_i` high and the block idle, a `start_i` high at rising edge N captures `addr_i` at edge N; on a hit `bank_cs_o` and `ack_o` rise after edge N+1 and fall after edge N+2 (one cycle wide). Later changes of `addr_i` do not alter the result.
- R3: Bank i matches when `bank_valid_i[i]` is 1 and (address AND mask) equals (base AND mask), where bank i's base and mask occupy bits [i*AW +: AW] of `bank_base_i` and `bank_mask_i`; bit i of `bank_cs_o` is bank i's chip select.
- R4: When several banks match, only the lowest-numbered one is selected; `bank_cs_o` never has more than one bit set.
- R5: An address matching no valid bank produces no acknowledge and no chip select.
- R6: With `sync_en_i` low, `start_i` is ignored and both outputs stay low.
- R7: With `async_en_i` high and the block idle, `strobe_i` set up before rising edge k is seen after two synchronizer flops; the address present at edge k+2 is captured, and on a hit `bank_cs_o` and `ack_o` rise after edge k+3.
- R8: For an asynchronous hit, `bank_cs_o` and `ack_o` stay high while `strobe_i` stays high; after `strobe_i` falls before edge j they are still high after edge j+1 and low after edge j+2.
- R9: With `async_en_i` low, `strobe_i` is ignored and both outputs stay low.
- R10: A start of either kind arriving while a transfer is in progress is ignored; the running transfer's chip select is unchanged.
- R11: `ack_o` is high exactly when `bank_cs_o` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sync_en_i | input | 1 | Enables synchronous master support |
| async_en_i | input | 1 | Enables asynchronous master support |
| bank_base_i | input | NBANK*AW | Packed bank base addresses |
| bank_mask_i | input | NBANK*AW | Packed bank address masks |
| bank_valid_i | input | NBANK | Per-bank valid bits |
| start_i | input | 1 | Synchronous transfer start pulse |
| strobe_i | input | 1 | Asynchronous address strobe, active high |
| addr_i | input | AW | Master address |
| bank_cs_o | output | NBANK | One-hot chip selects |
| ack_o | output | 1 | Transfer acknowledge |

## Verification
Synchronous transfers sweep every top address nibble with three second-nibble values under three valid-bit patterns, with banks laid out to overlap, so the sweep separates a wrong mask compare, a lost valid qualifier and a wrong priority order. Asynchronous transfers sweep the top nibble and change the address after capture, which separates decoding the captured address from decoding the live one, and also measure the synchronizer latency and the release delay. Starts with each enable low, and starts arriving during a held asynchronous transfer, tell an ignored start apart from one that disturbs the outputs.

// File: rtl/emf_pkg.sv
package emf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DEC   = 2'd1,
    ST_PULSE = 2'd2,
    ST_HOLD  = 2'd3
  } emf_state_e;

  typedef enum logic {
    SRC_SYNC  = 1'b0,
    SRC_ASYNC = 1'b1
  } emf_src_e;
endpackage

// File: rtl/emf_strobe_sync.sv
module emf_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], strobe_i};
  end

  // chain[STAGES-1] is the synchronized level, chain[STAGES] its delayed copy
  assign level_o = chain[STAGES-1];
  assign rise_o  = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/emf_bank_decoder.sv
module emf_bank_decoder #(
  parameter int NBANK = 4,
  parameter int AW    = 32
) (
  input  logic [AW-1:0]       addr_i,
  input  logic [NBANK*AW-1:0] base_i,
  input  logic [NBANK*AW-1:0] mask_i,
  input  logic [NBANK-1:0]    valid_i,
  output logic                hit_o,
  output logic [NBANK-1:0]    sel_o
);
  logic [NBANK-1:0] match;

  for (genvar g = 0; g < NBANK; g++) begin : g_cmp
    logic [AW-1:0] m;
    assign m        = mask_i[g*AW +: AW];
    assign match[g] = valid_i[g] && ((addr_i & m) == (base_i[g*AW +: AW] & m));
  end

  // lowest-numbered matching bank wins
  always_comb begin
    logic found;
    found = 1'b0;
    sel_o = '0;
    for (int i = 0; i < NBANK; i++) begin
      if (match[i] && !found) begin
        sel_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  assign hit_o = |match;
endmodule

// File: rtl/emf_ctrl.sv
module emf_ctrl
  import emf_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int AW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_en_i,
  input  logic             async_en_i,
  input  logic             start_i,
  input  logic             a_rise_i,
  input  logic             a_level_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             hit_i,
  input  logic [NBANK-1:0] sel_i,
  output logic [AW-1:0]    addr_q_o,
  output logic [NBANK-1:0] cs_o,
  output logic             ack_o
);
  emf_state_e state;
  emf_src_e   src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      src      <= SRC_SYNC;
      addr_q_o <= '0;
      cs_o     <= '0;
      ack_o    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (sync_en_i && start_i) begin
            addr_q_o <= addr_i;
            src      <= SRC_SYNC;
            state    <= ST_DEC;
          end else if (async_en_i && a_rise_i) begin
            addr_q_o <= addr_i;
            src      <= SRC_ASYNC;
            state    <= ST_DEC;
          end
        end
        ST_DEC: begin
          if (hit_i) begin
            cs_o  <= sel_i;
            ack_o <= 1'b1;
            state <= (src == SRC_SYNC) ? ST_PULSE : ST_HOLD;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_PULSE: begin
          cs_o  <= '0;
          ack_o <= 1'b0;
          state <= ST_IDLE;
        end
        ST_HOLD: begin
          if (!a_level_i) begin
            cs_o  <= '0;
            ack_o <= 1'b0;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ext_master_frontend.sv
module ext_master_frontend #(
  parameter int NBANK      = 4,
  parameter int AW         = 32,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sync_en_i,
  input  logic                async_en_i,
  input  logic [NBANK*AW-1:0] bank_base_i,
  input  logic [NBANK*AW-1:0] bank_mask_i,
  input  logic [NBANK-1:0]    bank_valid_i,
  input  logic                start_i,
  input  logic                strobe_i,
  input  logic [AW-1:0]       addr_i,
  output logic [NBANK-1:0]    bank_cs_o,
  output logic                ack_o
);
  logic             a_level, a_rise, hit;
  logic [NBANK-1:0] sel;
  logic [AW-1:0]    addr_q;

  emf_strobe_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (strobe_i),
    .level_o  (a_level),
    .rise_o   (a_rise)
  );

  emf_bank_decoder #(.NBANK(NBANK), .AW(AW)) u_dec (
    .addr_i  (addr_q),
    .base_i  (bank_base_i),
    .mask_i  (bank_mask_i),
    .valid_i (bank_valid_i),
    .hit_o   (hit),
    .sel_o   (sel)
  );

  emf_ctrl #(.NBANK(NBANK), .AW(AW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_en_i  (sync_en_i),
    .async_en_i (async_en_i),
    .start_i    (start_i),
    .a_rise_i   (a_rise),
    .a_level_i  (a_level),
    .addr_i     (addr_i),
    .hit_i      (hit),
    .sel_i      (sel),
    .addr_q_o   (addr_q),
    .cs_o       (bank_cs_o),
    .ack_o      (ack_o)
  );
endmodule

// File: rtl/emf_checker.sv
module emf_checker #(
  parameter int NBANK = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_en_i,
  input logic             async_en_i,
  input logic             start_i,
  input logic [NBANK-1:0] bank_cs_o,
  input logic             ack_o
);
  // R4: at most one chip select
  a_r4_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_cs_o));

  // R11: acknowledge accompanies a chip select
  a_r11_ack_cs_pair: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o == (bank_cs_o != '0));

  // R6 / R9: an acknowledge only follows an enabled start two edges earlier
  a_r6_r9_enabled_origin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> ($past(sync_en_i && start_i, 2) || $past(async_en_i, 2)));

  // R2: a synchronous acknowledge lasts one cycle
  a_r2_sync_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ack_o) && $past(sync_en_i && start_i, 2)) |=> !ack_o);
endmodule

bind ext_master_frontend emf_checker #(.NBANK(NBANK)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sync_en_i  (sync_en_i),
  .async_en_i (async_en_i),
  .start_i    (start_i),
  .bank_cs_o  (bank_cs_o),
  .ack_o      (ack_o)
);

// File: tb/sim_ext_master_frontend.sv
`timescale 1ns/1ps
module sim_ext_master_frontend;
  localparam int NB = 4;
  localparam int AW = 32;
  localparam logic [31:0] MISS = 32'hFFFF_FFF0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_en = 1'b0, async_en = 1'b0;
  logic [NB*AW-1:0] base, mask;
  logic [NB-1:0] valid;
  logic start = 1'b0, strobe = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [NB-1:0] cs;
  logic ack;

  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ext_master_frontend #(.NBANK(NB), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .sync_en_i(sync_en), .async_en_i(async_en),
    .bank_base_i(base), .bank_mask_i(mask), .bank_valid_i(valid),
    .start_i(start), .strobe_i(strobe), .addr_i(addr),
    .bank_cs_o(cs), .ack_o(ack)
  );

  function automatic logic [NB-1:0] exp_sel(input logic [31:0] a);
    for (int i = 0; i < NB; i++) begin
      logic [31:0] m;
      m = mask[i*AW +: AW];
      if (valid[i] && ((a & m) == (base[i*AW +: AW] & m))) return NB'(1) << i;
    end
    return '0;
  endfunction

  task automatic chk(input string tag, input logic [NB-1:0] exp_cs);
    total++;
    if (cs !== exp_cs || ack !== (exp_cs != '0)) begin
      bad++;
      $display("FAIL %s: cs=%b ack=%b expected cs=%b ack=%b", tag, cs, ack,
               exp_cs, exp_cs != '0);
    end
  endtask

  task automatic sync_xfer(input logic [31:0] a, input bit en, input string tag);
    logic [NB-1:0] e;
    e = en ? exp_sel(a) : '0;
    @(negedge clk); addr = a; start = 1'b1;
    @(negedge clk); start = 1'b0; addr = MISS;
    @(negedge clk); chk(tag, e);
    @(negedge clk); chk({tag, " R2 pulse end"}, '0);
  endtask

  task automatic async_xfer(input logic [31:0] a, input bit en, input string tag);
    logic [NB-1:0] e;
    e = en ? exp_sel(a) : '0;
    @(negedge clk); addr = a; strobe = 1'b1;
    repeat (3) @(negedge clk);
    addr = MISS;
    @(negedge clk); chk(tag, e);
    @(negedge clk); chk({tag, " R8 held"}, e);
    strobe = 1'b0;
    repeat (2) @(negedge clk); chk({tag, " R8 held j+1"}, e);
    @(negedge clk); chk({tag, " R8 released"}, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    base  = {32'h3000_0000, 32'h2100_0000, 32'h2000_0000, 32'h1000_0000};
    mask  = {32'hE000_0000, 32'hF000_0000, 32'hFF00_0000, 32'hF000_0000};
    valid = 4'b0111;
    repeat (3) @(negedge clk);
    chk("R1 in reset", '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 after reset", '0);

    sync_en = 1'b1; async_en = 1'b1;
    // R2 R3 R4 R5: sync sweep under three valid patterns
    for (int p = 0; p < 3; p++) begin
      valid = (p == 0) ? 4'b0111 : (p == 1) ? 4'b1111 : 4'b1010;
      for (int hi = 0; hi < 16; hi++)
        for (int mid = 0; mid < 3; mid++)
          sync_xfer((32'(hi) << 28) | (32'(mid) << 24) | 32'h1234, 1'b1,
                    "R2 R3 R4 R5 sync decode");
    end

    // R7 R8: async sweep
    valid = 4'b1111;
    for (int hi = 0; hi < 16; hi++)
      async_xfer((32'(hi) << 28) | 32'h0100_0000, 1'b1, "R7 R3 async decode");

    // R6: sync disabled
    sync_en = 1'b0;
    sync_xfer(32'h1000_0000, 1'b0, "R6 sync disabled");
    async_xfer(32'h1000_0000, 1'b1, "R7 async with sync off");
    sync_en = 1'b1;

    // R9: async disabled
    async_en = 1'b0;
    async_xfer(32'h2000_0000, 1'b0, "R9 async disabled");
    sync_xfer(32'h2000_0000, 1'b1, "R2 sync with async off");
    async_en = 1'b1;

    // R10: sync start during held async transfer
    @(negedge clk); addr = 32'h1000_0000; strobe = 1'b1;
    repeat (4) @(negedge clk); chk("R10 async held", 4'b0001);
    addr = 32'h2000_0000; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); chk("R10 start ignored", 4'b0001);
    @(negedge clk); chk("R10 start ignored later", 4'b0001);
    strobe = 1'b0;
    repeat (3) @(negedge clk); chk("R10 R8 release", '0);

    // R10: strobe during sync transfer is ignored
    @(negedge clk); addr = 32'h1000_0000; start = 1'b1; strobe = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); chk("R10 sync wins", 4'b0001);
    repeat (4) @(negedge clk); chk("R10 strobe ignored", '0);
    strobe = 1'b0;
    repeat (4) @(negedge clk); chk("R11 idle", '0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule